// File: doc/BRIEF.md
# Cascadable Vectored Priority Interrupt Controller

This controller watches eight device request lines and presents one interrupt line to a processor. Each line is given a fixed rank: line 0 ranks highest and line 7 lowest. When the processor acknowledges the interrupt, the controller returns a vector number. The vector is the sum of a programmable base and the index of the winning line. The controller records which lines are waiting and which are being served. A higher-ranked request may interrupt one that is still being served. A lower-ranked request must wait until software sends an end-of-service command for the higher one.

Two instances can be chained. The slave's interrupt output drives input 2 of the master, and the processor connects only to the master. When the master accepts an acknowledge for line 2, it forwards a one-cycle acknowledge pulse to the slave. It then returns the slave's vector in place of its own. Software writes the base, the mask and the end-of-service command through a small register port. The same port reads back the pending and in-service sets.

The sequencer has five states:
- IDLE: the interrupt output is low.
- RAISE: the interrupt output is high.
- DELIVER: the vector is presented.
- CAS_FWD: the acknowledge is being forwarded to the slave.
- CAS_WAIT: the master waits for the slave's vector.

The transitions are:
- IDLE to RAISE when an eligible request exists.
- RAISE to IDLE when no eligible request remains.
- RAISE to DELIVER on an accepted acknowledge for a local line.
- RAISE to CAS_FWD on an accepted acknowledge for line 2 in master mode.
- CAS_FWD to CAS_WAIT unconditionally.
- CAS_WAIT to DELIVER when the slave's vector-valid input is seen.
- DELIVER to IDLE unconditionally.

Top module: `intc_vector_ctrl`

## Requirements
- R1: A rising edge on `irq_i[k]` sets pending bit k. The bit stays set while the line is held high and until an acknowledge serves line k. A held level causes no second request.
- R2: Line 0 has the highest rank. `int_o` is high (within a few cycles) exactly when some pending, unmasked line outranks every in-service line.
- R3: An acknowledge (`ack_i` high in a cycle with `int_o` high) for a local line produces `vec_valid_o` for one cycle, in the cycle right after the acknowledge. In that cycle `vec_o` = base + line index, modulo 256.
- R4: An accepted acknowledge clears the winner's pending bit and sets its in-service bit.
- R5: The vector base resets to 32 and takes any 8-bit value written to register address 0.
- R6: A line whose mask bit is 1 never causes `int_o`. Its pending bit is still recorded and is served once the line is unmasked.
- R7: While line j is in service, requests on lines ranked below j (higher index) do not raise `int_o`. A request on a line ranked above j (lower index) raises it and nests.
- R8: Writing register address 2 is an end-of-service command. It clears only the lowest-index set in-service bit.
- R9: In master mode (`IS_MASTER`=1), acknowledging line 2 produces a one-cycle `cas_ack_o` pulse. The master then returns the slave's `cas_vec_i` with `vec_valid_o` three cycles after the acknowledge cycle.
- R10: Register map, selected by `reg_addr_i`:
  - Address 0: base, read/write.
  - Address 1: mask, read/write (bit k masks line k).
  - Address 2: pending set on read; end-of-service command on write.
  - Address 3: in-service set on read; writes are ignored.
  - After reset, the mask, pending and in-service sets are all 0.
- R11: An `ack_i` pulse while `int_o` is low is ignored: no vector is produced, and the pending and in-service sets do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| irq_i | input | 8 | Device request lines, edge-sensitive |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data, combinational from address |
| ack_i | input | 1 | Interrupt acknowledge from the processor or the master |
| int_o | output | 1 | Interrupt request toward the processor or the master |
| vec_valid_o | output | 1 | One-cycle vector strobe |
| vec_o | output | 8 | Vector number |
| cas_ack_o | output | 1 | Acknowledge forwarded to the slave |
| cas_vld_i | input | 1 | Vector strobe from the slave |
| cas_vec_i | input | 8 | Vector from the slave |

## Verification
A corrupted pending or in-service bit shows up at the ports within a few cycles. `int_o` rises when it should stay low, or stays low when it should rise. The register port's read-back of pending and in-service also disagrees after any settle interval. A wrong winner or base shows at the next acknowledge as a wrong `vec_o`. A broken sequencer shows as a missing or late `vec_valid_o`, or as a missing cascade pulse. The bench checks these at fixed latencies. Errors in priority or end-of-service ordering surface only when nested requests are pending together, so the bench drives those mixes on purpose.

// File: rtl/intc_pkg.sv
package intc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_RAISE    = 3'd1,
        ST_DELIVER  = 3'd2,
        ST_CAS_FWD  = 3'd3,
        ST_CAS_WAIT = 3'd4
    } intc_state_e;

    localparam logic [1:0] RA_BASE     = 2'd0;
    localparam logic [1:0] RA_MASK     = 2'd1;
    localparam logic [1:0] RA_PEND_EOI = 2'd2;
    localparam logic [1:0] RA_SERV     = 2'd3;

endpackage

// File: rtl/intc_edge_pend.sv
module intc_edge_pend #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] irq_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] pend_o
);

    logic [N-1:0] irq_q;
    logic [N-1:0] pend_q;
    logic [N-1:0] rise;

    assign rise = irq_i & ~irq_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q  <= '0;
            pend_q <= '0;
        end else begin
            irq_q  <= irq_i;
            // a fresh edge on the served line wins over the clear
            pend_q <= (pend_q & ~clr_i) | rise;
        end
    end

    assign pend_o = pend_q;

endmodule

// File: rtl/intc_prio_resolve.sv
module intc_prio_resolve #(
    parameter int N  = 8,
    parameter int IW = 3
) (
    input  logic [N-1:0]  pend_i,
    input  logic [N-1:0]  mask_i,
    input  logic [N-1:0]  isr_i,
    output logic          any_o,
    output logic [IW-1:0] idx_o,
    output logic [N-1:0]  win_oh_o,
    output logic [N-1:0]  top_isr_oh_o
);

    logic [N-1:0] allow;
    logic [N-1:0] elig;

    // a line may win only if nothing of equal or higher rank is in service
    for (genvar g = 0; g < N; g++) begin : g_allow
        assign allow[g] = ~|isr_i[g:0];
    end

    assign elig = pend_i & ~mask_i & allow;
    assign any_o = |elig;

    always_comb begin
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (elig[i]) idx_o = IW'(i);
        end
    end

    assign win_oh_o     = elig & (~elig + N'(1));
    assign top_isr_oh_o = isr_i & (~isr_i + N'(1));

endmodule

// File: rtl/intc_seq_fsm.sv
module intc_seq_fsm
    import intc_pkg::*;
#(
    parameter int N         = 8,
    parameter int IW        = 3,
    parameter int VEC_W     = 8,
    parameter int CAS_PIN   = 2,
    parameter bit IS_MASTER = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             any_i,
    input  logic [IW-1:0]    idx_i,
    input  logic [VEC_W-1:0] base_i,
    input  logic             ack_i,
    input  logic             cas_vld_i,
    input  logic [VEC_W-1:0] cas_vec_i,
    output logic             accept_o,
    output logic             int_o,
    output logic             vec_valid_o,
    output logic [VEC_W-1:0] vec_o,
    output logic             cas_ack_o
);

    intc_state_e state_q, state_d;
    logic [VEC_W-1:0] vec_q;
    logic             to_slave;

    assign accept_o = (state_q == ST_RAISE) && ack_i && any_i;
    assign to_slave = IS_MASTER && (idx_i == IW'(CAS_PIN));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (any_i) state_d = ST_RAISE;
            ST_RAISE: begin
                if (accept_o)    state_d = to_slave ? ST_CAS_FWD : ST_DELIVER;
                else if (!any_i) state_d = ST_IDLE;
            end
            ST_CAS_FWD:  state_d = ST_CAS_WAIT;
            ST_CAS_WAIT: if (cas_vld_i) state_d = ST_DELIVER;
            ST_DELIVER:  state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vec_q <= '0;
        end else if (accept_o && !to_slave) begin
            vec_q <= base_i + VEC_W'(idx_i);
        end else if (state_q == ST_CAS_WAIT && cas_vld_i) begin
            vec_q <= cas_vec_i;
        end
    end

    always_comb begin
        int_o       = 1'b0;
        vec_valid_o = 1'b0;
        cas_ack_o   = 1'b0;
        unique case (state_q)
            ST_RAISE:   int_o       = 1'b1;
            ST_DELIVER: vec_valid_o = 1'b1;
            ST_CAS_FWD: cas_ack_o   = 1'b1;
            default: ;
        endcase
    end

    assign vec_o = vec_q;

endmodule

// File: rtl/intc_vector_ctrl.sv
module intc_vector_ctrl
    import intc_pkg::*;
#(
    parameter int N          = 8,
    parameter int VEC_W      = 8,
    parameter int RESET_BASE = 32,
    parameter int CAS_PIN    = 2,
    parameter bit IS_MASTER  = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     irq_i,
    input  logic             reg_wr_i,
    input  logic [1:0]       reg_addr_i,
    input  logic [VEC_W-1:0] reg_wdata_i,
    output logic [VEC_W-1:0] reg_rdata_o,
    input  logic             ack_i,
    output logic             int_o,
    output logic             vec_valid_o,
    output logic [VEC_W-1:0] vec_o,
    output logic             cas_ack_o,
    input  logic             cas_vld_i,
    input  logic [VEC_W-1:0] cas_vec_i
);

    localparam int IW = (N > 1) ? $clog2(N) : 1;

    logic [VEC_W-1:0] base_q;
    logic [N-1:0]     mask_q;
    logic [N-1:0]     isr_q;
    logic [N-1:0]     pend_w;
    logic [N-1:0]     win_oh;
    logic [N-1:0]     top_isr_oh;
    logic [IW-1:0]    win_idx;
    logic             any_elig;
    logic             accept_w;
    logic             eoi_w;

    assign eoi_w = reg_wr_i && (reg_addr_i == RA_PEND_EOI);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= VEC_W'(RESET_BASE);
            mask_q <= '0;
        end else if (reg_wr_i) begin
            if (reg_addr_i == RA_BASE) base_q <= reg_wdata_i;
            if (reg_addr_i == RA_MASK) mask_q <= reg_wdata_i[N-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) isr_q <= '0;
        else        isr_q <= (isr_q & ~(eoi_w ? top_isr_oh : '0))
                           | (accept_w ? win_oh : '0);
    end

    intc_edge_pend #(.N(N)) u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .irq_i  (irq_i),
        .clr_i  (accept_w ? win_oh : '0),
        .pend_o (pend_w)
    );

    intc_prio_resolve #(.N(N), .IW(IW)) u_prio (
        .pend_i       (pend_w),
        .mask_i       (mask_q),
        .isr_i        (isr_q),
        .any_o        (any_elig),
        .idx_o        (win_idx),
        .win_oh_o     (win_oh),
        .top_isr_oh_o (top_isr_oh)
    );

    intc_seq_fsm #(
        .N(N), .IW(IW), .VEC_W(VEC_W), .CAS_PIN(CAS_PIN), .IS_MASTER(IS_MASTER)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .any_i       (any_elig),
        .idx_i       (win_idx),
        .base_i      (base_q),
        .ack_i       (ack_i),
        .cas_vld_i   (cas_vld_i),
        .cas_vec_i   (cas_vec_i),
        .accept_o    (accept_w),
        .int_o       (int_o),
        .vec_valid_o (vec_valid_o),
        .vec_o       (vec_o),
        .cas_ack_o   (cas_ack_o)
    );

    always_comb begin
        unique case (reg_addr_i)
            RA_BASE:     reg_rdata_o = base_q;
            RA_MASK:     reg_rdata_o = VEC_W'(mask_q);
            RA_PEND_EOI: reg_rdata_o = VEC_W'(pend_w);
            RA_SERV:     reg_rdata_o = VEC_W'(isr_q);
            default:     reg_rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/intc_vector_ctrl_chk.sv
module intc_vector_ctrl_chk #(
    parameter int N = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         int_o,
    input logic         vec_valid_o,
    input logic         cas_ack_o,
    input logic         ack_i,
    input logic         eoi_w,
    input logic         accept_w,
    input logic [N-1:0] pend,
    input logic [N-1:0] isr,
    input logic [N-1:0] mask
);

    // R2: a raised request always has something pending behind it
    p_int_has_pending_r2: assert property (@(posedge clk) disable iff (!rst_n)
        int_o |-> (pend != '0));

    // R3: the vector strobe lasts a single cycle
    p_vec_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid_o |=> !vec_valid_o);

    // R4: in-service changes only through an acknowledge or end-of-service
    p_isr_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(isr) |-> $past(ack_i || eoi_w));

    // R6: all lines masked keeps a quiet output quiet
    p_mask_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '1 && !int_o) |=> !int_o);

    // R8: end-of-service drops exactly one in-service bit
    p_eoi_one_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_w && isr != '0 && !accept_w) |=> ($countones(isr) + 1 == $past($countones(isr))));

    // R9: the forwarded acknowledge is a single-cycle pulse
    p_cas_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cas_ack_o |=> !cas_ack_o);

endmodule

bind intc_vector_ctrl intc_vector_ctrl_chk #(.N(N)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .int_o       (int_o),
    .vec_valid_o (vec_valid_o),
    .cas_ack_o   (cas_ack_o),
    .ack_i       (ack_i),
    .eoi_w       (eoi_w),
    .accept_w    (accept_w),
    .pend        (pend_w),
    .isr         (isr_q),
    .mask        (mask_q)
);

// File: tb/tb_intc_vector_ctrl.sv
module tb_intc_vector_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] m_dev = '0, s_dev = '0;
    logic       m_wr = 1'b0, s_wr = 1'b0;
    logic [1:0] m_addr = '0, s_addr = '0;
    logic [7:0] m_wdata = '0, s_wdata = '0;
    logic [7:0] m_rdata, s_rdata;
    logic       cpu_ack = 1'b0;
    logic       m_int, m_vv, m_casack, s_int, s_vv, s_casack;
    logic [7:0] m_vec, s_vec;
    logic [7:0] m_irq;

    int n_tests = 0, n_fail = 0;
    int cas_cnt = 0, vv_cnt = 0;

    logic [7:0] mp = '0, mi = '0, mm = '0, sp = '0, si = '0, sm = '0;
    logic [7:0] mb = 8'd32, sb = 8'd32;

    always #5 clk = ~clk;

    assign m_irq = {m_dev[7:3], s_int, m_dev[1:0]};

    intc_vector_ctrl #(.IS_MASTER(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .irq_i(m_irq),
        .reg_wr_i(m_wr), .reg_addr_i(m_addr), .reg_wdata_i(m_wdata), .reg_rdata_o(m_rdata),
        .ack_i(cpu_ack), .int_o(m_int), .vec_valid_o(m_vv), .vec_o(m_vec),
        .cas_ack_o(m_casack), .cas_vld_i(s_vv), .cas_vec_i(s_vec)
    );

    intc_vector_ctrl #(.IS_MASTER(1'b0)) u_slave (
        .clk(clk), .rst_n(rst_n), .irq_i(s_dev),
        .reg_wr_i(s_wr), .reg_addr_i(s_addr), .reg_wdata_i(s_wdata), .reg_rdata_o(s_rdata),
        .ack_i(m_casack), .int_o(s_int), .vec_valid_o(s_vv), .vec_o(s_vec),
        .cas_ack_o(s_casack), .cas_vld_i(1'b0), .cas_vec_i(8'h00)
    );

    always @(negedge clk) begin
        if (m_casack) cas_cnt++;
        if (m_vv) vv_cnt++;
    end

    function automatic logic [7:0] elig_f(logic [7:0] p, logic [7:0] i, logic [7:0] m);
        logic [7:0] r = '0;
        for (int j = 0; j < 8; j++)
            if (p[j] && !m[j] && ((int'(i) & ((2 << j) - 1)) == 0)) r[j] = 1'b1;
        return r;
    endfunction

    function automatic int first_f(logic [7:0] v);
        int r = -1;
        for (int j = 7; j >= 0; j--) if (v[j]) r = j;
        return r;
    endfunction

    function automatic logic [7:0] mp_eff();
        return (mp & 8'hFB) | ((elig_f(sp, si, sm) != 0) ? 8'h04 : 8'h00);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd(bit slv, logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        if (slv) s_addr = a; else m_addr = a;
        #1 d = slv ? s_rdata : m_rdata;
    endtask

    task automatic wr(bit slv, logic [1:0] a, logic [7:0] d);
        @(negedge clk);
        if (slv) begin s_wr = 1; s_addr = a; s_wdata = d; end
        else     begin m_wr = 1; m_addr = a; m_wdata = d; end
        @(negedge clk);
        s_wr = 0; m_wr = 0;
    endtask

    task automatic settle();
        logic [7:0] d;
        tick(6);
        chk("R2 int_o level", m_int, elig_f(mp_eff(), mi, mm) != 0);
        rd(0, 2'd2, d); chk("R4 master pending", d, mp_eff());
        rd(0, 2'd3, d); chk("R4 master in-service", d, mi);
        rd(1, 2'd3, d); chk("R4 slave in-service", d, si);
    endtask

    task automatic pulse_lines(logic [7:0] m, logic [7:0] s);
        @(negedge clk);
        m_dev = m & 8'hFB; s_dev = s;
        @(negedge clk);
        m_dev = '0; s_dev = '0;
        mp |= m & 8'hFB; sp |= s;
    endtask

    task automatic service(output logic [7:0] got_vec);
        int w, sw, c0, lat;
        logic [7:0] exp;
        bit got;
        w = first_f(elig_f(mp_eff(), mi, mm));
        chk("R2 int_o before ack", m_int, 1);
        if (w == 2) begin
            sw = first_f(elig_f(sp, si, sm));
            exp = sb + 8'(sw);
            sp[sw] = 1'b0; si[sw] = 1'b1;
        end else begin
            exp = mb + 8'(w);
            mp[w] = 1'b0;
        end
        mi[w] = 1'b1;
        c0 = cas_cnt;
        @(negedge clk) cpu_ack = 1;
        @(negedge clk) cpu_ack = 0;
        got = 0; lat = -1; got_vec = '0;
        for (int k = 0; k < 10 && !got; k++) begin
            #1;
            if (m_vv) begin got = 1; got_vec = m_vec; lat = k; end
            else @(negedge clk);
        end
        if (w == 2) begin
            chk("R9 cascade vector", got_vec, exp);
            chk("R9 cascade latency", lat, 2);
            chk("R9 forwarded ack count", cas_cnt - c0, 1);
        end else begin
            chk("R3 vector", got_vec, exp);
            chk("R3 latency", lat, 0);
            chk("R9 no forward for local line", cas_cnt - c0, 0);
        end
        settle();
    endtask

    task automatic eoi();
        int w;
        w = first_f(mi);
        if (w == 2 && si != 0) begin
            wr(1, 2'd2, 8'h00);
            si[first_f(si)] = 1'b0;
        end
        wr(0, 2'd2, 8'h00);
        if (w >= 0) mi[w] = 1'b0;
        settle();
    endtask

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] d, v;
        int c0, guard;
        void'($urandom(32'h5EED));
        tick(3);
        rst_n = 1;
        tick(2);

        // R5 / R10 reset state
        rd(0, 2'd0, d); chk("R5 reset base", d, 8'd32);
        rd(0, 2'd1, d); chk("R10 reset mask", d, 0);
        rd(0, 2'd2, d); chk("R10 reset pending", d, 0);
        rd(0, 2'd3, d); chk("R10 reset in-service", d, 0);
        chk("R2 reset int_o", m_int, 0);

        // R11 stray acknowledge
        c0 = vv_cnt;
        @(negedge clk) cpu_ack = 1;
        @(negedge clk) cpu_ack = 0;
        tick(4);
        chk("R11 no vector on stray ack", vv_cnt - c0, 0);
        settle();

        // R10 write to in-service address ignored
        wr(0, 2'd3, 8'hFF);
        rd(0, 2'd3, d); chk("R10 in-service write ignored", d, 0);

        // R1 held level: one request only
        @(negedge clk) m_dev = 8'h10;
        mp |= 8'h10;
        settle();
        service(v); chk("R1 vector line 4", v, 8'd36);
        rd(0, 2'd2, d); chk("R1 no retrigger while held", d, 0);
        chk("R1 int low while held", m_int, 0);
        @(negedge clk) m_dev = 0;
        eoi();

        // R7 nesting and R8 end-of-service order
        pulse_lines(8'h20, 0); settle();
        service(v); chk("R7 line 5 vector", v, 8'd37);
        pulse_lines(8'h40, 0); settle();
        chk("R7 lower rank waits", m_int, 0);
        pulse_lines(8'h02, 0); settle();
        chk("R7 higher rank nests", m_int, 1);
        service(v); chk("R7 nested vector", v, 8'd33);
        eoi();
        rd(0, 2'd3, d); chk("R8 only top bit cleared", d, 8'h20);
        chk("R8 line 6 still blocked", m_int, 0);
        eoi();
        service(v); chk("R7 released vector", v, 8'd38);
        eoi();

        // R6 masking
        wr(0, 2'd1, 8'h01); mm = 8'h01;
        pulse_lines(8'h01, 0); settle();
        chk("R6 masked line quiet", m_int, 0);
        rd(0, 2'd2, d); chk("R6 pending still recorded", d, 8'h01);
        wr(0, 2'd1, 8'h00); mm = 8'h00;
        settle();
        service(v); chk("R6 served after unmask", v, 8'd32);
        eoi();

        // R5 base change with wrap
        wr(0, 2'd0, 8'hFC); mb = 8'hFC;
        pulse_lines(8'h80, 0); settle();
        service(v); chk("R5 wrapped vector", v, 8'h03);
        eoi();

        // R9 cascade through line 2
        wr(1, 2'd0, 8'h70); sb = 8'h70;
        pulse_lines(0, 8'h08); settle();
        service(v); chk("R9 slave vector", v, 8'h73);
        eoi();

        // constrained random mixes
        for (int it = 0; it < 60; it++) begin
            if ($urandom % 4 == 0) begin
                mm = 8'($urandom) & 8'hFB; wr(0, 2'd1, mm);
                sm = 8'($urandom) & 8'($urandom); wr(1, 2'd1, sm);
            end
            if ($urandom % 6 == 0) begin
                mb = 8'($urandom); wr(0, 2'd0, mb);
                sb = 8'($urandom); wr(1, 2'd0, sb);
            end
            pulse_lines(8'($urandom), 8'($urandom) & 8'($urandom));
            settle();
            guard = 0;
            while ((mi != 0 || elig_f(mp_eff(), mi, mm) != 0) && guard < 80) begin
                guard++;
                if (elig_f(mp_eff(), mi, mm) != 0 && (mi == 0 || $urandom % 3 != 0))
                    service(v);
                else
                    eoi();
                if ($urandom % 5 == 0) begin
                    pulse_lines(8'($urandom) & 8'($urandom), 8'($urandom) & 8'($urandom));
                    settle();
                end
            end
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule